// File: doc/BRIEF.md
# Event-Driven Power Sequencing Engine

This block is a programmable state machine that stages the power-up and power-down of a board. It drives eight enable outputs from the state it is in. Each state holds an output pattern, a warning flag and three ways out. A monitor exit and a fault exit each fire when a condition over the input flag vector holds for a programmed number of cycles. A timeout exit fires after a programmed number of cycles spent in the state. The input flag vector carries supply-good flags and logic inputs.

A timeout exit back into a recovery state serves as a watchdog check. A state with its warning flag set raises the interrupt output for as long as the engine stays in it. The program lives in a table of 63 state entries. Software writes that table one field at a time through a simple write port, and may rewrite it while the engine runs.

Top module: `pwrseq_engine`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, `state_o` is 0, `enable_o` is 0 and `irq_o` is 0. Reset also clears every table field to zero. With every condition disabled and every timeout off, the engine then stays in state 0 whatever the flags do.
- R2: `enable_o` equals the pattern of the current state and `irq_o` equals its warning flag. Both change on the clock edge that changes the state. After a write to the current state's pattern field, both take the new value from the edge that performs the write.
- R3: A write takes place on a clock edge while `cfg_we_i` is high. It goes to the entry `cfg_state_i`, and only when that value is below 63. `cfg_field_i` picks the field. Code 0 is the pattern: bits 7:0 are the enables and bit 8 is the warning flag. Code 1 is the monitor condition and code 3 is the fault condition. Each condition has a mask in bits 11:0, a match value in bits 23:12, an any-of mode in bit 24 and an enable in bit 25. Code 2 is the monitor hold-and-destination and code 4 is the fault hold-and-destination. Each has the hold count in bits 15:0 and the next state in bits 21:16. Code 5 is the timeout, with the cycle count in bits 15:0 and the next state in bits 21:16. Codes 6 and 7 write nothing.
- R4: A flag agrees when it equals its match bit. An enabled condition is true in the default mode when every masked flag agrees. In any-of mode it is true when at least one masked flag agrees. A disabled condition is never true.
- R5: With hold count H, an exit fires in the cycle where its condition has been true for H+1 consecutive cycles with the masked flags unchanged. With H = 0 it fires in the first cycle the condition is true. The engine moves to that exit's next state on the edge that ends the cycle.
- R6: The hold count restarts when the condition goes false. It also restarts when any masked flag changes value, even if the condition stays true. The cycle of the change counts as the first cycle of the new run.
- R7: A timeout count T > 0 fires in the T-th cycle spent in the state. T = 0 disables the timeout. The timeout count and both hold counts restart every time a transition is taken.
- R8: When several exits fire in one cycle, the fault exit wins over the monitor exit, and the monitor exit wins over the timeout exit.
- R9: A next state of 63 is not a state. An exit that fires towards it is discarded, and the next exit in priority order is considered. If no exit remains, the state holds. `state_o` never shows 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_state_i | input | 6 | Table entry to write |
| cfg_field_i | input | 3 | Field code within the entry |
| cfg_data_i | input | 26 | Field value |
| flags_i | input | 12 | Supply-good flags and logic inputs |
| enable_o | output | 8 | Output enable pattern of the current state |
| irq_o | output | 1 | Warning interrupt of the current state |
| state_o | output | 6 | Current state |

## Verification
Conditions are evaluated on the flags present in a cycle, so a completing flag value moves `state_o`, `enable_o` and `irq_o` on the very next clock edge. A hold count H needs H+1 sampled cycles of the condition before that edge, and a timeout T moves the state on the edge ending the T-th cycle after entry. The bench changes flags and write strobes on the falling edge and reads the outputs on the following falling edge, so each check lands one edge after its stimulus. Hold and timeout checks therefore step one falling edge per cycle and compare the expected state at each step.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;

   typedef enum logic [2:0] {
      FLD_PATTERN  = 3'd0,
      FLD_MON_COND = 3'd1,
      FLD_MON_DEST = 3'd2,
      FLD_FLT_COND = 3'd3,
      FLD_FLT_DEST = 3'd4,
      FLD_TIMEOUT  = 3'd5
   } cfg_field_e;

   localparam int EXIT_MON = 0;
   localparam int EXIT_FLT = 1;
   localparam int N_COND_EXITS = 2;

endpackage

// File: rtl/pwrseq_cfg_table.sv
`timescale 1ns/1ps
module pwrseq_cfg_table
   import pwrseq_pkg::*;
#(
   parameter int NUM_OUT    = 8,
   parameter int NUM_IN     = 12,
   parameter int STATE_W    = 6,
   parameter int NUM_STATES = 63,
   parameter int HOLD_W     = 16,
   parameter int TMO_W      = 16,
   parameter int CFG_W      = 26,
   localparam int COND_W    = 2 * NUM_IN + 2,
   localparam int DEST_W    = HOLD_W + STATE_W,
   localparam int TWORD_W   = TMO_W + STATE_W
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               we_i,
   input  logic [STATE_W-1:0] wstate_i,
   input  logic [2:0]         wfield_i,
   input  logic [CFG_W-1:0]   wdata_i,
   input  logic [STATE_W-1:0] rstate_i,
   output logic [NUM_OUT-1:0] pattern_o,
   output logic               warn_o,
   output logic [COND_W-1:0]  mon_cond_o,
   output logic [DEST_W-1:0]  mon_dest_o,
   output logic [COND_W-1:0]  flt_cond_o,
   output logic [DEST_W-1:0]  flt_dest_o,
   output logic [TWORD_W-1:0] tmo_word_o
);

   localparam logic [STATE_W-1:0] LAST_STATE = STATE_W'(NUM_STATES - 1);

   logic [NUM_OUT:0]    pat_q  [NUM_STATES];
   logic [COND_W-1:0]   mcond_q[NUM_STATES];
   logic [DEST_W-1:0]   mdest_q[NUM_STATES];
   logic [COND_W-1:0]   fcond_q[NUM_STATES];
   logic [DEST_W-1:0]   fdest_q[NUM_STATES];
   logic [TWORD_W-1:0]  tword_q[NUM_STATES];

   logic wr_ok;
   assign wr_ok = we_i && (wstate_i <= LAST_STATE);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         for (int s = 0; s < NUM_STATES; s++) begin
            pat_q[s]   <= '0;
            mcond_q[s] <= '0;
            mdest_q[s] <= '0;
            fcond_q[s] <= '0;
            fdest_q[s] <= '0;
            tword_q[s] <= '0;
         end
      end else if (wr_ok) begin
         case (cfg_field_e'(wfield_i))
            FLD_PATTERN:  pat_q[wstate_i]   <= wdata_i[NUM_OUT:0];
            FLD_MON_COND: mcond_q[wstate_i] <= wdata_i[COND_W-1:0];
            FLD_MON_DEST: mdest_q[wstate_i] <= wdata_i[DEST_W-1:0];
            FLD_FLT_COND: fcond_q[wstate_i] <= wdata_i[COND_W-1:0];
            FLD_FLT_DEST: fdest_q[wstate_i] <= wdata_i[DEST_W-1:0];
            FLD_TIMEOUT:  tword_q[wstate_i] <= wdata_i[TWORD_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      pattern_o  = '0;
      warn_o     = 1'b0;
      mon_cond_o = '0;
      mon_dest_o = '0;
      flt_cond_o = '0;
      flt_dest_o = '0;
      tmo_word_o = '0;
      if (rstate_i <= LAST_STATE) begin
         pattern_o  = pat_q[rstate_i][NUM_OUT-1:0];
         warn_o     = pat_q[rstate_i][NUM_OUT];
         mon_cond_o = mcond_q[rstate_i];
         mon_dest_o = mdest_q[rstate_i];
         flt_cond_o = fcond_q[rstate_i];
         flt_dest_o = fdest_q[rstate_i];
         tmo_word_o = tword_q[rstate_i];
      end
   end

endmodule

// File: rtl/pwrseq_cond_timer.sv
`timescale 1ns/1ps
module pwrseq_cond_timer #(
   parameter int NUM_IN  = 12,
   parameter int HOLD_W  = 16,
   parameter int STATE_W = 6,
   localparam int COND_W = 2 * NUM_IN + 2,
   localparam int DEST_W = HOLD_W + STATE_W
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               restart_i,
   input  logic [NUM_IN-1:0]  flags_i,
   input  logic [COND_W-1:0]  cond_word_i,
   input  logic [DEST_W-1:0]  dest_word_i,
   output logic               cond_o,
   output logic               fire_o,
   output logic [STATE_W-1:0] next_o
);

   localparam logic [HOLD_W-1:0] HOLD_MAX = '1;

   logic [NUM_IN-1:0] mask, match, agree;
   logic              any_mode, enabled, moved;
   logic [HOLD_W-1:0] hold, run, cnt_q;
   logic [NUM_IN-1:0] prev_q;

   assign mask     = cond_word_i[NUM_IN-1:0];
   assign match    = cond_word_i[2*NUM_IN-1:NUM_IN];
   assign any_mode = cond_word_i[2*NUM_IN];
   assign enabled  = cond_word_i[2*NUM_IN+1];
   assign hold     = dest_word_i[HOLD_W-1:0];
   assign next_o   = dest_word_i[HOLD_W +: STATE_W];

   assign agree  = ~(flags_i ^ match) & mask;
   assign cond_o = enabled && (any_mode ? (|agree) : (agree == mask));
   assign moved  = |((flags_i ^ prev_q) & mask);
   assign run    = moved ? '0 : cnt_q;
   assign fire_o = cond_o && (run >= hold);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prev_q <= '0;
         cnt_q  <= '0;
      end else begin
         prev_q <= flags_i;
         if (restart_i || !cond_o) begin
            cnt_q <= '0;
         end else if (run != HOLD_MAX) begin
            cnt_q <= run + 1'b1;
         end else begin
            cnt_q <= run;
         end
      end
   end

endmodule

// File: rtl/pwrseq_tmo_timer.sv
`timescale 1ns/1ps
module pwrseq_tmo_timer #(
   parameter int TMO_W   = 16,
   parameter int STATE_W = 6,
   localparam int TWORD_W = TMO_W + STATE_W
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               restart_i,
   input  logic [TWORD_W-1:0] word_i,
   output logic               fire_o,
   output logic [STATE_W-1:0] next_o
);

   localparam logic [TMO_W-1:0] TMO_MAX = '1;

   logic [TMO_W-1:0] limit, cnt_q;

   assign limit  = word_i[TMO_W-1:0];
   assign next_o = word_i[TMO_W +: STATE_W];
   assign fire_o = (limit != '0) && (cnt_q == limit - 1'b1);

   always_ff @(posedge clk_i) begin
      if (rst_i || restart_i) begin
         cnt_q <= '0;
      end else if (cnt_q != TMO_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pwrseq_engine.sv
`timescale 1ns/1ps
module pwrseq_engine
   import pwrseq_pkg::*;
#(
   parameter int NUM_OUT    = 8,
   parameter int NUM_IN     = 12,
   parameter int STATE_W    = 6,
   parameter int NUM_STATES = 63,
   parameter int HOLD_W     = 16,
   parameter int TMO_W      = 16,
   parameter int CFG_W      = 2 * NUM_IN + 2
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               cfg_we_i,
   input  logic [STATE_W-1:0] cfg_state_i,
   input  logic [2:0]         cfg_field_i,
   input  logic [CFG_W-1:0]   cfg_data_i,
   input  logic [NUM_IN-1:0]  flags_i,
   output logic [NUM_OUT-1:0] enable_o,
   output logic               irq_o,
   output logic [STATE_W-1:0] state_o
);

   localparam int COND_W  = 2 * NUM_IN + 2;
   localparam int DEST_W  = HOLD_W + STATE_W;
   localparam int TWORD_W = TMO_W + STATE_W;
   localparam logic [STATE_W-1:0] LAST_STATE = STATE_W'(NUM_STATES - 1);

   if (NUM_STATES < 1 || NUM_STATES > (2 ** STATE_W) - 1) begin : g_bad_states
      $error("NUM_STATES must leave one code of STATE_W free as the invalid target");
   end
   if (CFG_W < COND_W || CFG_W < DEST_W || CFG_W < TWORD_W || CFG_W < NUM_OUT + 1) begin : g_bad_cfg_w
      $error("CFG_W is too narrow for one of the table fields");
   end
   if (HOLD_W < 1 || TMO_W < 1 || NUM_IN < 1 || NUM_OUT < 1) begin : g_bad_widths
      $error("all widths must be at least one bit");
   end

   logic [STATE_W-1:0] state_q, state_d;
   logic               take;

   logic [NUM_OUT-1:0] pattern;
   logic               warn;
   logic [COND_W-1:0]  mon_cword, flt_cword;
   logic [DEST_W-1:0]  mon_dword, flt_dword;
   logic [TWORD_W-1:0] tmo_word;

   pwrseq_cfg_table #(
      .NUM_OUT   (NUM_OUT),
      .NUM_IN    (NUM_IN),
      .STATE_W   (STATE_W),
      .NUM_STATES(NUM_STATES),
      .HOLD_W    (HOLD_W),
      .TMO_W     (TMO_W),
      .CFG_W     (CFG_W)
   ) u_table (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .we_i      (cfg_we_i),
      .wstate_i  (cfg_state_i),
      .wfield_i  (cfg_field_i),
      .wdata_i   (cfg_data_i),
      .rstate_i  (state_q),
      .pattern_o (pattern),
      .warn_o    (warn),
      .mon_cond_o(mon_cword),
      .mon_dest_o(mon_dword),
      .flt_cond_o(flt_cword),
      .flt_dest_o(flt_dword),
      .tmo_word_o(tmo_word)
   );

   logic [COND_W-1:0]  cword [N_COND_EXITS];
   logic [DEST_W-1:0]  dword [N_COND_EXITS];
   logic               cfire [N_COND_EXITS];
   logic               ctrue [N_COND_EXITS];
   logic [STATE_W-1:0] cnext [N_COND_EXITS];

   assign cword[EXIT_MON] = mon_cword;
   assign dword[EXIT_MON] = mon_dword;
   assign cword[EXIT_FLT] = flt_cword;
   assign dword[EXIT_FLT] = flt_dword;

   for (genvar g = 0; g < N_COND_EXITS; g++) begin : g_cond
      pwrseq_cond_timer #(
         .NUM_IN (NUM_IN),
         .HOLD_W (HOLD_W),
         .STATE_W(STATE_W)
      ) u_cond (
         .clk_i      (clk_i),
         .rst_i      (rst_i),
         .restart_i  (take),
         .flags_i    (flags_i),
         .cond_word_i(cword[g]),
         .dest_word_i(dword[g]),
         .cond_o     (ctrue[g]),
         .fire_o     (cfire[g]),
         .next_o     (cnext[g])
      );
   end

   logic               mon_fire, flt_fire, mon_cond, flt_cond, tmo_fire;
   logic [STATE_W-1:0] mon_next, flt_next, tmo_next;

   assign mon_fire = cfire[EXIT_MON];
   assign mon_cond = ctrue[EXIT_MON];
   assign mon_next = cnext[EXIT_MON];
   assign flt_fire = cfire[EXIT_FLT];
   assign flt_cond = ctrue[EXIT_FLT];
   assign flt_next = cnext[EXIT_FLT];

   pwrseq_tmo_timer #(
      .TMO_W  (TMO_W),
      .STATE_W(STATE_W)
   ) u_tmo (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .restart_i(take),
      .word_i   (tmo_word),
      .fire_o   (tmo_fire),
      .next_o   (tmo_next)
   );

   // Priority: fault, then monitor, then timeout; exits aimed at an
   // unused code are dropped so the next one down gets its chance.
   always_comb begin
      take    = 1'b0;
      state_d = state_q;
      if (flt_fire && (flt_next <= LAST_STATE)) begin
         take    = 1'b1;
         state_d = flt_next;
      end else if (mon_fire && (mon_next <= LAST_STATE)) begin
         take    = 1'b1;
         state_d = mon_next;
      end else if (tmo_fire && (tmo_next <= LAST_STATE)) begin
         take    = 1'b1;
         state_d = tmo_next;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= '0;
      end else begin
         state_q <= state_d;
      end
   end

   assign enable_o = pattern;
   assign irq_o    = warn;
   assign state_o  = state_q;

endmodule

// File: rtl/pwrseq_engine_chk.sv
`timescale 1ns/1ps
module pwrseq_engine_chk #(
   parameter int STATE_W    = 6,
   parameter int NUM_STATES = 63
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic [STATE_W-1:0] state_i,
   input logic               mon_fire_i,
   input logic [STATE_W-1:0] mon_next_i,
   input logic               flt_fire_i,
   input logic [STATE_W-1:0] flt_next_i,
   input logic               tmo_fire_i,
   input logic [STATE_W-1:0] tmo_next_i
);

   localparam logic [STATE_W-1:0] TOP_CODE = STATE_W'(NUM_STATES - 1);

   logic flt_ok, mon_ok, tmo_ok;
   assign flt_ok = flt_fire_i && (flt_next_i <= TOP_CODE);
   assign mon_ok = mon_fire_i && (mon_next_i <= TOP_CODE);
   assign tmo_ok = tmo_fire_i && (tmo_next_i <= TOP_CODE);

   // R1: reset puts the engine in state 0
   assert_reset_state_R1: assert property (@(posedge clk_i)
      rst_i |=> (state_i == '0));

   // R8: a valid fault exit always decides the next state
   assert_fault_first_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      flt_ok |=> (state_i == $past(flt_next_i)));

   // R8: monitor beats timeout when no valid fault exit fires
   assert_monitor_second_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (!flt_ok && mon_ok) |=> (state_i == $past(mon_next_i)));

   // R9: with no usable exit the state holds
   assert_hold_without_exit_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (!flt_ok && !mon_ok && !tmo_ok) |=> $stable(state_i));

   // R9: the unused code never appears as the current state
   always @(posedge clk_i) begin
      if (!rst_i) begin
         assert_state_in_range_R9: assert (state_i <= TOP_CODE)
            else $error("state left the programmed range");
      end
   end

endmodule

bind pwrseq_engine pwrseq_engine_chk #(
   .STATE_W   (STATE_W),
   .NUM_STATES(NUM_STATES)
) u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .state_i   (state_q),
   .mon_fire_i(mon_fire),
   .mon_next_i(mon_next),
   .flt_fire_i(flt_fire),
   .flt_next_i(flt_next),
   .tmo_fire_i(tmo_fire),
   .tmo_next_i(tmo_next)
);

// File: tb/pwrseq_engine_tb_top.sv
`timescale 1ns/1ps
module pwrseq_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_state = '0;
   logic [2:0]  cfg_field = '0;
   logic [25:0] cfg_data = '0;
   logic [11:0] flags = '0;
   logic [7:0]  enable_o;
   logic        irq_o;
   logic [5:0]  state_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pwrseq_engine dut_i (
      .clk_i      (clk),
      .rst_i      (rst),
      .cfg_we_i   (cfg_we),
      .cfg_state_i(cfg_state),
      .cfg_field_i(cfg_field),
      .cfg_data_i (cfg_data),
      .flags_i    (flags),
      .enable_o   (enable_o),
      .irq_o      (irq_o),
      .state_o    (state_o)
   );

   // R3 field codes
   localparam logic [2:0] F_PAT = 3'd0, F_MC = 3'd1, F_MD = 3'd2,
                          F_FC = 3'd3, F_FD = 3'd4, F_TMO = 3'd5;

   function automatic logic [25:0] cw(input logic [11:0] m, input logic [11:0] v,
                                      input logic any, input logic en);
      return {en, any, v, m};
   endfunction

   function automatic logic [25:0] dw(input logic [15:0] n, input logic [5:0] nxt);
      return {4'b0, nxt, n};
   endfunction

   // {flags, expected state, expected enables, expected irq}
   localparam int NV = 27;
   localparam logic [26:0] VEC [0:NV-1] = '{
      {12'h000, 6'd0,  8'h00, 1'b0},
      {12'h001, 6'd1,  8'h01, 1'b0},
      {12'h003, 6'd1,  8'h01, 1'b0},
      {12'h003, 6'd1,  8'h01, 1'b0},
      {12'h001, 6'd1,  8'h01, 1'b0},
      {12'h003, 6'd1,  8'h01, 1'b0},
      {12'h003, 6'd1,  8'h01, 1'b0},
      {12'h003, 6'd1,  8'h01, 1'b0},
      {12'h003, 6'd2,  8'h03, 1'b0},
      {12'h007, 6'd2,  8'h03, 1'b0},
      {12'h007, 6'd2,  8'h03, 1'b0},
      {12'h00F, 6'd2,  8'h03, 1'b0},
      {12'h00F, 6'd2,  8'h03, 1'b0},
      {12'h00F, 6'd2,  8'h03, 1'b0},
      {12'h00F, 6'd2,  8'h03, 1'b0},
      {12'h00F, 6'd3,  8'hFF, 1'b0},
      {12'h00F, 6'd3,  8'hFF, 1'b0},
      {12'h00E, 6'd4,  8'h0F, 1'b0},
      {12'h00E, 6'd4,  8'h0F, 1'b0},
      {12'h00E, 6'd0,  8'h00, 1'b0},
      {12'h00E, 6'd0,  8'h00, 1'b0},
      {12'h001, 6'd1,  8'h01, 1'b0},
      {12'h801, 6'd10, 8'h00, 1'b1},
      {12'h801, 6'd10, 8'h00, 1'b1},
      {12'hC01, 6'd0,  8'h00, 1'b0},
      {12'h000, 6'd0,  8'h00, 1'b0},
      {12'h001, 6'd1,  8'h01, 1'b0}
   };

   task automatic expect_out(input string tag, input logic [5:0] st,
                             input logic [7:0] en, input logic ir);
      checks++;
      if (state_o !== st || enable_o !== en || irq_o !== ir) begin
         fails++;
         $display("FAIL %s: state=%0d enable=%h irq=%b expected state=%0d enable=%h irq=%b",
                  tag, state_o, enable_o, irq_o, st, en, ir);
      end
   endtask

   task automatic cyc(input logic [11:0] f);
      flags = f;
      @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] s, input logic [2:0] fld, input logic [25:0] d);
      cfg_we    = 1'b1;
      cfg_state = s;
      cfg_field = fld;
      cfg_data  = d;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_out("R1 during reset", 6'd0, 8'h00, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      expect_out("R1 after reset", 6'd0, 8'h00, 1'b0);

      // R3: program a staged power-up, a power-down and a fault path
      wr(6'd0,  F_PAT, 26'h000);
      wr(6'd0,  F_MC,  cw(12'h001, 12'h001, 1'b0, 1'b1));
      wr(6'd0,  F_MD,  dw(16'd0, 6'd1));
      wr(6'd1,  F_PAT, 26'h001);
      wr(6'd1,  F_MC,  cw(12'h002, 12'h002, 1'b0, 1'b1));
      wr(6'd1,  F_MD,  dw(16'd3, 6'd2));
      wr(6'd1,  F_FC,  cw(12'h800, 12'h800, 1'b0, 1'b1));
      wr(6'd1,  F_FD,  dw(16'd0, 6'd10));
      wr(6'd1,  F_TMO, dw(16'd20, 6'd10));
      wr(6'd2,  F_PAT, 26'h003);
      wr(6'd2,  F_MC,  cw(12'h00C, 12'h00C, 1'b1, 1'b1));
      wr(6'd2,  F_MD,  dw(16'd4, 6'd3));
      wr(6'd3,  F_PAT, 26'h0FF);
      wr(6'd3,  F_MC,  cw(12'h001, 12'h000, 1'b0, 1'b1));
      wr(6'd3,  F_MD,  dw(16'd0, 6'd4));
      wr(6'd3,  F_FC,  cw(12'h800, 12'h800, 1'b0, 1'b1));
      wr(6'd3,  F_FD,  dw(16'd0, 6'd10));
      wr(6'd4,  F_PAT, 26'h00F);
      wr(6'd4,  F_TMO, dw(16'd2, 6'd0));
      wr(6'd10, F_PAT, 26'h100);
      wr(6'd10, F_MC,  cw(12'h400, 12'h400, 1'b0, 1'b1));
      wr(6'd10, F_MD,  dw(16'd0, 6'd0));

      // Vector walk: R2 patterns, R4 all/any/low modes, R5 hold, R6 restarts, R7 timeout
      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i][26:15]);
         expect_out($sformatf("R2 R4 R5 R6 R7 vector %0d", i),
                    VEC[i][14:9], VEC[i][8:1], VEC[i][0]);
      end

      // R7: timeout of 20 in state 1, fresh count after re-entry
      for (int k = 1; k < 20; k++) begin
         cyc(12'h001);
         expect_out($sformatf("R7 timeout wait cycle %0d", k), 6'd1, 8'h01, 1'b0);
      end
      cyc(12'h001);
      expect_out("R7 timeout fires on cycle 20", 6'd10, 8'h00, 1'b1);
      cyc(12'h400);
      expect_out("R5 recovery exit", 6'd0, 8'h00, 1'b0);
      cyc(12'h000);
      expect_out("R4 idle in state 0", 6'd0, 8'h00, 1'b0);

      // R8 priority setup
      wr(6'd0, F_MD,  dw(16'd0, 6'd6));
      wr(6'd6, F_PAT, 26'h055);
      wr(6'd6, F_FC,  cw(12'h800, 12'h800, 1'b0, 1'b1));
      wr(6'd6, F_FD,  dw(16'd0, 6'd7));
      wr(6'd6, F_MC,  cw(12'h800, 12'h800, 1'b0, 1'b1));
      wr(6'd6, F_MD,  dw(16'd0, 6'd8));
      wr(6'd6, F_TMO, dw(16'd1, 6'd9));
      wr(6'd7, F_PAT, 26'h077);
      wr(6'd7, F_TMO, dw(16'd1, 6'd0));
      wr(6'd8, F_PAT, 26'h088);
      wr(6'd8, F_TMO, dw(16'd1, 6'd0));
      wr(6'd9, F_PAT, 26'h099);
      wr(6'd9, F_TMO, dw(16'd1, 6'd63));
      expect_out("R3 writes leave state alone", 6'd0, 8'h00, 1'b0);

      cyc(12'h801);
      expect_out("R8 enter state 6", 6'd6, 8'h55, 1'b0);
      cyc(12'h801);
      expect_out("R8 fault beats monitor and timeout", 6'd7, 8'h77, 1'b0);
      cyc(12'h000);
      expect_out("R7 one-cycle timeout", 6'd0, 8'h00, 1'b0);
      wr(6'd6, F_FC, 26'h0);
      cyc(12'h801);
      expect_out("R8 enter state 6 again", 6'd6, 8'h55, 1'b0);
      cyc(12'h801);
      expect_out("R4 R8 monitor beats timeout, fault disabled", 6'd8, 8'h88, 1'b0);
      cyc(12'h000);
      expect_out("R7 back to 0", 6'd0, 8'h00, 1'b0);
      cyc(12'h001);
      expect_out("R8 enter state 6 third time", 6'd6, 8'h55, 1'b0);
      cyc(12'h000);
      expect_out("R8 timeout alone", 6'd9, 8'h99, 1'b0);
      for (int k = 0; k < 3; k++) begin
         cyc(12'h000);
         expect_out($sformatf("R9 invalid target holds %0d", k), 6'd9, 8'h99, 1'b0);
      end

      wr(6'd9, F_PAT, 26'h1A5);
      expect_out("R2 R3 live pattern rewrite", 6'd9, 8'hA5, 1'b1);

      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      expect_out("R1 reset mid-run", 6'd0, 8'h00, 1'b0);
      cyc(12'h001);
      expect_out("R1 cleared table stays in 0", 6'd0, 8'h00, 1'b0);
      cyc(12'hFFF);
      expect_out("R1 cleared table ignores flags", 6'd0, 8'h00, 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule